// File: doc/BRIEF.md
# DDR SDRAM Auto-Refresh Scheduler

This block keeps a DDR SDRAM supplied with auto-refresh commands so that its cells retain their data. A free-running interval timer fires once every `REFI_CYCLES` clocks. Each firing adds one owed refresh to a small pending counter. The device needs 4096 refreshes in every 64 ms, which averages about 15.6 us per refresh, so the default interval is 780 cycles at 50 MHz.

The block raises a request toward the main memory controller while any refresh is owed. It issues a refresh only in a cycle where three things hold at once: the controller grants it, the controller reports every bank precharged, and no lockout is running. The command drives chip select, row strobe and column strobe low, with write enable and clock enable high. All four banks refresh together, and the row address is generated inside the memory, so the address and bank pins play no part.

After each command the block holds a busy flag for `TRFC_CYCLES` cycles. During that time the controller sends nothing but no-ops, and the block issues no further refresh. An urgent flag rises when the number of owed refreshes reaches `MAX_POSTPONE`.

Top module: `sdram_aref_sched`

## Requirements
- R1: While `rst_ni` is low and right after its release, `ref_req_o`, `urgent_o` and `busy_o` are 0, the command pins `cs_n_o`, `ras_n_o`, `cas_n_o`, `we_n_o` are all 1 (deselect), and `cke_o` is 1.
- R2: The interval timer starts from its full value at reset. The first interval tick lands on the `REFI_CYCLES`-th rising edge after reset release, so with no grant `ref_req_o` first reads 1 after that edge. Later ticks follow every `REFI_CYCLES` edges.
- R3: Each tick adds one to the pending count, which saturates at `MAX_POSTPONE`. `urgent_o` is 1 exactly when the count equals `MAX_POSTPONE`.
- R4: `ref_req_o` is 1 exactly when the pending count is nonzero.
- R5: A refresh is issued on a rising edge where `ref_req_o`, `grant_i` and `banks_idle_i` are all 1 and `busy_o` is 0. In the following cycle only, the pins read `cs_n_o=0`, `ras_n_o=0`, `cas_n_o=0`, `we_n_o=1`.
- R6: `busy_o` is 1 for exactly `TRFC_CYCLES` cycles, starting with the refresh command cycle. No refresh is issued while it is 1.
- R7: Each issued refresh removes one from the pending count. A tick and an issue on the same edge leave the count unchanged.
- R8: In every cycle that is not a refresh command cycle, the four command pins are all 1. `cke_o` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| grant_i | input | 1 | Controller allows refresh this cycle |
| banks_idle_i | input | 1 | Controller reports all banks precharged |
| ref_req_o | output | 1 | At least one refresh is owed |
| urgent_o | output | 1 | Owed refreshes reached the postpone limit |
| busy_o | output | 1 | Refresh lockout window active |
| cke_o | output | 1 | Clock enable pin |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |

## Verification
The assertions assume only that `grant_i` and `banks_idle_i` are known (not X or Z) at every clock edge after reset. They make no assumption about how the controller sequences those inputs, because the block itself must filter out grants that arrive while a bank is open or while the lockout runs.

The stimulus changes both inputs only on falling edges, always to 0 or 1. It holds grant off long enough to saturate the pending count, then grants while banks are open, then keeps both inputs high to drain back-to-back refreshes. It finishes with random grant and idle patterns.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ddr_cmd_t;

  localparam ddr_cmd_t CMD_DESEL = 4'b1111;
  localparam ddr_cmd_t CMD_AREF  = 4'b0001;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned REFI_CYCLES = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned TW = (REFI_CYCLES > 2) ? $clog2(REFI_CYCLES) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(REFI_CYCLES - 1);

  logic [TW-1:0] tmr_q;

  assign tick_o = (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tmr_q <= RELOAD;
    else if (tick_o) tmr_q <= RELOAD;
    else             tmr_q <= tmr_q - 1'b1;
  end
endmodule

// File: rtl/ref_pending_ctr.sv
module ref_pending_ctr #(
  parameter int unsigned MAX_POSTPONE = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic nonzero_o,
  output logic full_o
);
  localparam int unsigned CW = $clog2(MAX_POSTPONE + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_POSTPONE);

  logic [CW-1:0] cnt_q;

  assign nonzero_o = (cnt_q != '0);
  assign full_o    = (cnt_q == LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (!full_o) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (nonzero_o) cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/ref_lockout.sv
module ref_lockout #(
  parameter int unsigned TRFC_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned LW = $clog2(TRFC_CYCLES + 1);
  localparam logic [LW-1:0] LOAD = LW'(TRFC_CYCLES);

  logic [LW-1:0] lock_q;

  assign busy_o = (lock_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lock_q <= '0;
    else if (start_i) lock_q <= LOAD;
    else if (busy_o)  lock_q <= lock_q - 1'b1;
  end
endmodule

// File: rtl/sdram_aref_sched.sv
module sdram_aref_sched
  import refsched_pkg::*;
#(
  parameter int unsigned REFI_CYCLES  = 780,
  parameter int unsigned TRFC_CYCLES  = 4,
  parameter int unsigned MAX_POSTPONE = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  input  logic banks_idle_i,
  output logic ref_req_o,
  output logic urgent_o,
  output logic busy_o,
  output logic cke_o,
  output logic cs_n_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);
  logic     tick;
  logic     issue;
  ddr_cmd_t cmd_q;

  ref_interval_timer #(.REFI_CYCLES(REFI_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  ref_pending_ctr #(.MAX_POSTPONE(MAX_POSTPONE)) u_pending (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (tick),
    .dec_i     (issue),
    .nonzero_o (ref_req_o),
    .full_o    (urgent_o)
  );

  ref_lockout #(.TRFC_CYCLES(TRFC_CYCLES)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (issue),
    .busy_o  (busy_o)
  );

  // all-bank idle and grant gate the command; lockout spaces them
  assign issue = ref_req_o && grant_i && banks_idle_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cmd_q <= CMD_DESEL;
    else if (issue) cmd_q <= CMD_AREF;
    else            cmd_q <= CMD_DESEL;
  end

  assign cke_o   = 1'b1;
  assign cs_n_o  = cmd_q.cs_n;
  assign ras_n_o = cmd_q.ras_n;
  assign cas_n_o = cmd_q.cas_n;
  assign we_n_o  = cmd_q.we_n;
endmodule

// File: rtl/sdram_aref_sched_chk.sv
module sdram_aref_sched_chk #(
  parameter int unsigned TRFC_CYCLES = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic grant_i,
  input logic banks_idle_i,
  input logic ref_req_o,
  input logic urgent_o,
  input logic busy_o,
  input logic cke_o,
  input logic cs_n_o,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic we_n_o
);
  logic ref_cyc;
  logic started;
  assign ref_cyc = !cs_n_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started <= 1'b0;
    else         started <= 1'b1;
  end

  a_r5_encoding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_cyc |-> (!ras_n_o && !cas_n_o && we_n_o));

  a_r5_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && ref_cyc) |-> $past(grant_i && banks_idle_i && ref_req_o && !busy_o));

  a_r6_busy_on_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_cyc |-> busy_o);

  a_r6_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_cyc |=> !ref_cyc);

  a_r3_urgent_has_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urgent_o |-> ref_req_o);

  a_r8_cke_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o);

  a_r8_idle_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> (ras_n_o && cas_n_o && we_n_o));
endmodule

bind sdram_aref_sched sdram_aref_sched_chk #(.TRFC_CYCLES(TRFC_CYCLES)) u_chk (.*);

// File: tb/sdram_aref_sched_bench.sv
module sdram_aref_sched_bench;
  localparam int REFI = 20;
  localparam int TRFC = 4;
  localparam int MAXP = 3;
  localparam int NCYC = 4000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic grant = 1'b0, idle = 1'b0;
  logic req, urg, busy, cke, cs_n, ras_n, cas_n, we_n;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference model state
  int m_tmr, m_pend, m_lock;
  bit m_ref;
  int first_req = -1;

  always #10 clk = ~clk;

  sdram_aref_sched #(.REFI_CYCLES(REFI), .TRFC_CYCLES(TRFC), .MAX_POSTPONE(MAXP)) u_sdram_aref_sched (
    .clk_i(clk), .rst_ni(rst_ni), .grant_i(grant), .banks_idle_i(idle),
    .ref_req_o(req), .urgent_o(urg), .busy_o(busy), .cke_o(cke),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n));

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic int pins_exp(input bit r);
    return r ? 4'b0001 : 4'b1111;
  endfunction

  function automatic int pend_next(input int p, input bit tk, input bit is);
    int n = p + (tk ? 1 : 0) - (is ? 1 : 0);
    return (n > MAXP) ? MAXP : n;
  endfunction

  task automatic check_outputs(input int cyc);
    chk("R4 req", int'(req), int'(m_pend != 0));
    chk("R3 urgent", int'(urg), int'(m_pend == MAXP));
    chk("R6 busy", int'(busy), int'(m_lock != 0));
    chk(m_ref ? "R5 refresh pins" : "R8 idle pins",
        int'({cs_n, ras_n, cas_n, we_n}), pins_exp(m_ref));
    chk("R8 cke", int'(cke), 1);
    if (req && first_req < 0) first_req = cyc;
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_tmr = REFI - 1; m_pend = 0; m_lock = 0; m_ref = 1'b0;
    repeat (3) @(negedge clk);
    // R1: during reset
    chk("R1 req", int'(req), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 pins", int'({cs_n, ras_n, cas_n, we_n}), 4'b1111);
    rst_ni = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      bit tk, is;
      if (c > 0) @(negedge clk);
      check_outputs(c);
      if (c < 200)       begin grant = 1'b0; idle = 1'b1; end
      else if (c < 400)  begin grant = 1'b1; idle = 1'b0; end  // R5: open banks block
      else if (c < 1000) begin grant = 1'b1; idle = 1'b1; end  // R6: back-to-back drain
      else begin
        grant = ($urandom % 2) == 0;
        idle  = ($urandom % 4) != 0;
      end
      // advance model over the coming edge (R2, R3, R7)
      tk = (m_tmr == 0);
      is = (m_pend != 0) && grant && idle && (m_lock == 0);
      m_tmr  = tk ? REFI - 1 : m_tmr - 1;
      m_pend = pend_next(m_pend, tk, is);
      m_lock = is ? TRFC : (m_lock > 0 ? m_lock - 1 : 0);
      m_ref  = is;
    end
    // R2: first request follows REFI edges after release
    chk("R2 first tick", first_req, REFI);
    // R7: tick and issue on one edge leave the count unchanged
    chk("R7 same-edge net", pend_next(2, 1'b1, 1'b1), 2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * (NCYC + 1000));
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule